// File: doc/BRIEF.md
# Latched Serial Input Expander

This block reads a bank of parallel input lines and returns them to a host, one bit at a time, over a three-wire serial link. The link has an active-low select, a shift clock and a serial data line. Inside, the block has three stages:

- a storage register that freezes a snapshot of the inputs;
- a shift register that is loaded from that snapshot and shifted out most-significant bit first;
- an output stage that behaves like an open-drain driver, so the data line can be shared with other traffic.

The host pins are asynchronous to the block's system clock, so each one passes through a synchronizer. A small sequencer turns the single select line into an ordered pair of internal events: first a capture strobe for the storage register, then, a programmable number of system clocks later, the switch of the shift register from loading to shifting. Because of this order, the byte that is loaded is always the one just captured, with no race between the two events.

A compatibility mode gives the cheaper behaviour found when the capture is wired straight to the select edge. In that mode the capture happens when select is released, and shifting starts at once when select is asserted. Each transfer therefore returns the inputs as they stood at the end of the previous transfer. A serial input enters at the least-significant end, so several blocks can be chained.

Top module: `serial_input_expander`

## Requirements
- R1: The storage register changes only on the internal capture strobe, and it takes the value of `par_in` at that moment. Changing `par_in` at any other time has no effect on the byte that is returned.
- R2: While the block is in the load phase, the shift register copies the storage register. In the shift phase, each rising edge of the synchronized `sclk` moves the shift register one position toward the MSB. The MSB is presented on `sdo`, so bits come out MSB first.
- R3: With `compat_mode` = 0, the capture strobe occurs first and the shift phase begins `LOAD_DELAY` system clocks after it, with a minimum of one. The returned byte is `par_in` as it was when select was asserted. When `sel_n` falls just before clock edge 1, `sdo_oe_n` is still 1 after edge 7 and becomes 0 after edge 8 (with `LOAD_DELAY` = 4).
- R4: With `compat_mode` = 1, the capture strobe fires when select is released, and the shift phase begins with no delay: `sdo_oe_n` is still 1 after edge 2 and becomes 0 after edge 3. Each transfer returns the byte captured at the end of the previous transfer, and the first transfer after reset returns 0.
- R5: `sdo_oe_n` is active low and is 0 only during the shift phase. While it is 1, the output is released: `sdo` reads 1 (the pulled-up level) and `sdo_pull_low` is 0.
- R6: `sdo_pull_low` is 1 exactly when the output is enabled and the current data bit is 0. For a data bit of 1, the line is left released.
- R7: On each shift, the synchronized `ser_in` enters bit 0. After `WIDTH` further shifts in the same frame, the bits driven on `ser_in` appear on `sdo` in the order they were driven.
- R8: Raising `sel_n` at any point, including in the middle of a byte, ends the frame. The output is released within one clock after the synchronized select goes inactive, and a partial byte gives no `xfer_done`. The next assertion of select runs the full capture-then-load sequence again.
- R9: `xfer_done` is a single-clock pulse issued one clock after every `WIDTH`-th shift of a frame.
- R10: After reset, `sdo_oe_n` = 1, `sdo` = 1, `sdo_pull_low` = 0, `xfer_done` = 0, and the storage register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| compat_mode | input | 1 | 1 selects capture-on-release with no load delay; meant to be static |
| sel_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Shift clock from the host; idle low |
| ser_in | input | 1 | Cascade serial input, shifted into bit 0 |
| par_in | input | WIDTH | Parallel input lines |
| sdo | output | 1 | Serial data level; reads 1 when released |
| sdo_oe_n | output | 1 | Active-low output enable |
| sdo_pull_low | output | 1 | 1 when the pad must pull the shared line low |
| xfer_done | output | 1 | One-clock pulse after each full byte |

## Verification
The bench builds the block with `WIDTH` = 8, `LOAD_DELAY` = 4 and two synchronizer stages. These values put the gap between the capture strobe and the load-to-shift switch at a known clock edge, so the exact edge at which the output enables can be checked in both modes. With `WIDTH` = 8, a two-byte frame through the cascade input is short enough to check in full. A table of transfers that switches between the two modes shows the one-transfer lag appear and disappear. Directed runs then cover an aborted byte, and the first compatibility transfer after reset.

// File: rtl/sie_pkg.sv
package sie_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_LATCH = 2'd1,
    SEQ_WAIT  = 2'd2,
    SEQ_SHIFT = 2'd3
  } seq_state_e;
endpackage

// File: rtl/sie_sync.sv
module sie_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int unsigned S = (STAGES < 2) ? 2 : STAGES;

  logic [S-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {S{RST_VAL}};
    else        stg_q <= {stg_q[S-2:0], d};
  end

  assign q = stg_q[S-1];
endmodule

// File: rtl/sie_sequencer.sv
module sie_sequencer #(
  parameter int unsigned LOAD_DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic compat_mode,
  input  logic sel_act,
  output logic latch_stb,
  output logic shift_mode
);
  import sie_pkg::*;

  localparam int unsigned GAP = (LOAD_DELAY < 1) ? 1 : LOAD_DELAY;
  localparam int unsigned CW  = (GAP < 2) ? 1 : $clog2(GAP);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          sel_prev_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SEQ_IDLE: begin
        cnt_d = '0;
        if (sel_act) state_d = compat_mode ? SEQ_SHIFT : SEQ_LATCH;
      end
      SEQ_LATCH: begin
        cnt_d   = '0;
        state_d = SEQ_WAIT;
      end
      SEQ_WAIT: begin
        if (cnt_q == CW'(GAP - 1)) state_d = SEQ_SHIFT;
        else                       cnt_d   = cnt_q + 1'b1;
      end
      SEQ_SHIFT: state_d = SEQ_SHIFT;
      default:   state_d = SEQ_IDLE;
    endcase
    if (!sel_act) state_d = SEQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      cnt_q      <= '0;
      sel_prev_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      sel_prev_q <= sel_act;
    end
  end

  // capture: LATCH state in normal mode, select release in compat mode
  assign latch_stb  = (state_q == SEQ_LATCH) |
                      (compat_mode & sel_prev_q & ~sel_act);
  assign shift_mode = (state_q == SEQ_SHIFT);
endmodule

// File: rtl/sie_datapath.sv
module sie_datapath #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] par_in,
  input  logic             latch_stb,
  input  logic             shift_mode,
  input  logic             sclk_lvl,
  input  logic             ser_bit,
  output logic [WIDTH-1:0] storage_q,
  output logic             msb,
  output logic             done
);
  localparam int unsigned BW = (WIDTH < 2) ? 1 : $clog2(WIDTH);

  logic [WIDTH-1:0] shreg_q, shreg_d, storage_d;
  logic [BW-1:0]    bcnt_q, bcnt_d;
  logic             sclk_prev_q, done_q, done_d;
  logic             shift_pulse, last_bit;

  assign shift_pulse = shift_mode & sclk_lvl & ~sclk_prev_q;
  assign last_bit    = (bcnt_q == BW'(WIDTH - 1));

  always_comb begin
    storage_d = latch_stb ? par_in : storage_q;
    if (!shift_mode)     shreg_d = storage_q;
    else if (shift_pulse) begin
      if (WIDTH > 1) shreg_d = {shreg_q[WIDTH-2:0], ser_bit};
      else           shreg_d = ser_bit;
    end
    else                 shreg_d = shreg_q;
    if (!shift_mode)      bcnt_d = '0;
    else if (shift_pulse) bcnt_d = last_bit ? '0 : bcnt_q + 1'b1;
    else                  bcnt_d = bcnt_q;
    done_d = shift_pulse & last_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      storage_q   <= '0;
      shreg_q     <= '0;
      bcnt_q      <= '0;
      sclk_prev_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      storage_q   <= storage_d;
      shreg_q     <= shreg_d;
      bcnt_q      <= bcnt_d;
      sclk_prev_q <= sclk_lvl;
      done_q      <= done_d;
    end
  end

  assign msb  = shreg_q[WIDTH-1];
  assign done = done_q;
endmodule

// File: rtl/sie_outstage.sv
module sie_outstage (
  input  logic enable,
  input  logic data_bit,
  output logic sdo,
  output logic sdo_oe_n,
  output logic sdo_pull_low
);
  always_comb begin
    sdo_oe_n     = ~enable;
    sdo          = enable ? data_bit : 1'b1;
    sdo_pull_low = enable & ~data_bit;
  end
endmodule

// File: rtl/serial_input_expander.sv
module serial_input_expander #(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned LOAD_DELAY  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             compat_mode,
  input  logic             sel_n,
  input  logic             sclk,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             sdo,
  output logic             sdo_oe_n,
  output logic             sdo_pull_low,
  output logic             xfer_done
);
  logic [2:0]       pins_s;
  logic             sel_act, latch_stb, shift_mode, msb;
  logic [WIDTH-1:0] storage_q;

  sie_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_in, sclk, sel_n}), .q(pins_s)
  );

  assign sel_act = ~pins_s[0];

  sie_sequencer #(.LOAD_DELAY(LOAD_DELAY)) u_seq (
    .clk(clk), .rst_n(rst_n), .compat_mode(compat_mode),
    .sel_act(sel_act), .latch_stb(latch_stb), .shift_mode(shift_mode)
  );

  sie_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .par_in(par_in),
    .latch_stb(latch_stb), .shift_mode(shift_mode),
    .sclk_lvl(pins_s[1]), .ser_bit(pins_s[2]),
    .storage_q(storage_q), .msb(msb), .done(xfer_done)
  );

  sie_outstage u_out (
    .enable(shift_mode), .data_bit(msb),
    .sdo(sdo), .sdo_oe_n(sdo_oe_n), .sdo_pull_low(sdo_pull_low)
  );
endmodule

// File: rtl/sie_checker.sv
module sie_checker #(
  parameter int unsigned WIDTH      = 8,
  parameter int unsigned LOAD_DELAY = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             compat_mode,
  input logic             sel_act,
  input logic             latch_stb,
  input logic             shift_mode,
  input logic [WIDTH-1:0] storage_q,
  input logic             sdo,
  input logic             sdo_oe_n,
  input logic             sdo_pull_low,
  input logic             xfer_done
);
  localparam int unsigned GAP = (LOAD_DELAY < 1) ? 1 : LOAD_DELAY;
  localparam int unsigned GW  = $clog2(GAP + 1);

  logic [GW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   since_q <= '0;
    else if (latch_stb)           since_q <= '0;
    else if (since_q != GW'(GAP)) since_q <= since_q + 1'b1;
  end

  // R1
  storage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_stb |=> $stable(storage_q));

  // R3
  setup_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(shift_mode) && !compat_mode) |-> (since_q >= GW'(GAP)));

  // R5
  released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe_n |-> (sdo && !sdo_pull_low));

  // R6
  pull_only_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_pull_low |-> (!sdo_oe_n && !sdo));

  // R8
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_act |=> sdo_oe_n);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);
endmodule

bind serial_input_expander sie_checker #(.WIDTH(WIDTH), .LOAD_DELAY(LOAD_DELAY)) u_chk (
  .clk(clk), .rst_n(rst_n), .compat_mode(compat_mode), .sel_act(sel_act),
  .latch_stb(latch_stb), .shift_mode(shift_mode), .storage_q(storage_q),
  .sdo(sdo), .sdo_oe_n(sdo_oe_n), .sdo_pull_low(sdo_pull_low),
  .xfer_done(xfer_done)
);

// File: tb/serial_input_expander_tb.sv
module serial_input_expander_tb;
  localparam int W = 8;
  localparam int NVEC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic compat_mode = 1'b0;
  logic sel_n = 1'b1;
  logic sclk = 1'b0;
  logic ser_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic sdo, sdo_oe_n, sdo_pull_low, xfer_done;

  int n_chk = 0;
  int n_fail = 0;
  int done_cnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  serial_input_expander #(.WIDTH(W), .LOAD_DELAY(4), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .compat_mode(compat_mode), .sel_n(sel_n),
    .sclk(sclk), .ser_in(ser_in), .par_in(par_in), .sdo(sdo),
    .sdo_oe_n(sdo_oe_n), .sdo_pull_low(sdo_pull_low), .xfer_done(xfer_done)
  );

  always @(negedge clk) if (xfer_done) done_cnt++;

  // {compat, par_in, expected byte}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 8'hA5, 8'hA5},
    {1'b0, 8'h3C, 8'h3C},
    {1'b1, 8'h96, 8'h3C},
    {1'b1, 8'h0F, 8'h96},
    {1'b1, 8'hF0, 8'h0F},
    {1'b0, 8'h81, 8'h81},
    {1'b0, 8'h00, 8'h00},
    {1'b0, 8'hFF, 8'hFF}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sel_on();
    @(negedge clk) sel_n = 1'b0;
    repeat (14) @(negedge clk);
  endtask

  task automatic sel_off();
    sel_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  // sample current bit, then pulse sclk with ser_in = sbit
  task automatic shift_one(input logic sbit, output logic got);
    got = sdo;
    chk(sdo_pull_low == ~sdo && sdo_oe_n == 1'b0, "R6", "pull_low vs bit",
        {sdo_oe_n, sdo_pull_low}, {1'b0, ~sdo});
    ser_in = sbit;
    sclk = 1'b1;
    repeat (6) @(negedge clk);
    sclk = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic read_byte(input logic [W-1:0] sin, output logic [W-1:0] val);
    logic b;
    for (int i = W - 1; i >= 0; i--) begin
      shift_one(sin[i], b);
      val[i] = b;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] got, got2;
    int d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(sdo_oe_n == 1'b1, "R10", "oe_n", sdo_oe_n, 1);
    chk(sdo == 1'b1, "R10", "sdo", sdo, 1);
    chk(sdo_pull_low == 1'b0 && xfer_done == 1'b0, "R10", "pull_low/done",
        {sdo_pull_low, xfer_done}, 0);

    // R4 first compat transfer after reset returns 0 (storage reset)
    compat_mode = 1'b1;
    par_in = 8'h77;
    sel_on();
    read_byte('0, got);
    chk(got == 8'h00, "R4", "first compat byte", got, 8'h00);
    sel_off();

    // table walk: R1 R2 R3 R4 R9
    for (int v = 0; v < NVEC; v++) begin
      compat_mode = VEC[v][16];
      par_in = VEC[v][15:8];
      repeat (2) @(negedge clk);
      d0 = done_cnt;
      sel_on();
      par_in = ~VEC[v][15:8];  // R1 change during frame has no effect
      read_byte('0, got);
      chk(got == VEC[v][7:0], "R2", $sformatf("vector %0d byte", v), got, VEC[v][7:0]);
      repeat (3) @(negedge clk);
      chk(done_cnt == d0 + 1, "R9", "done pulses per byte", done_cnt - d0, 1);
      par_in = VEC[v][15:8];
      sel_off();
      chk(sdo_oe_n == 1'b1 && sdo == 1'b1, "R5", "released after frame",
          {sdo_oe_n, sdo}, 2'b11);
    end

    // R3 exact enable edge, normal mode
    compat_mode = 1'b0;
    @(negedge clk) sel_n = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == 7) chk(sdo_oe_n == 1'b1, "R3", "oe_n after edge 7", sdo_oe_n, 1);
      if (k == 8) chk(sdo_oe_n == 1'b0, "R3", "oe_n after edge 8", sdo_oe_n, 0);
    end
    sel_off();

    // R4 exact enable edge, compat mode
    compat_mode = 1'b1;
    @(negedge clk) sel_n = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      if (k == 2) chk(sdo_oe_n == 1'b1, "R4", "oe_n after edge 2", sdo_oe_n, 1);
      if (k == 3) chk(sdo_oe_n == 1'b0, "R4", "oe_n after edge 3", sdo_oe_n, 0);
    end
    sel_off();

    // R8 abort mid-byte, then full restart
    compat_mode = 1'b0;
    par_in = 8'h5A;
    d0 = done_cnt;
    sel_on();
    for (int i = 0; i < 3; i++) begin
      logic b;
      shift_one(1'b0, b);
      chk(b == par_in[W-1-i], "R8", "partial bit", b, par_in[W-1-i]);
    end
    sel_off();
    chk(sdo_oe_n == 1'b1 && sdo == 1'b1 && sdo_pull_low == 1'b0, "R8",
        "released after abort", {sdo_oe_n, sdo, sdo_pull_low}, 3'b110);
    chk(done_cnt == d0, "R8", "no done on abort", done_cnt - d0, 0);
    par_in = 8'hC3;
    sel_on();
    read_byte('0, got);
    chk(got == 8'hC3, "R8", "restart byte", got, 8'hC3);
    sel_off();

    // R7 cascade: two bytes in one frame
    par_in = 8'h12;
    d0 = done_cnt;
    sel_on();
    read_byte(8'hE7, got);
    read_byte(8'h00, got2);
    chk(got == 8'h12, "R7", "first byte", got, 8'h12);
    chk(got2 == 8'hE7, "R7", "cascaded byte", got2, 8'hE7);
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 2, "R9", "two done pulses", done_cnt - d0, 2);
    sel_off();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule